// File: doc/BRIEF.md
# E1 Receive Backplane Frame Pulse Generator

This block produces the single framing indication that accompanies one received E1 stream on the backplane. It runs on the bit clock and keeps its own position counters. A bit counter spans a 256-bit frame, which is 32 timeslots of 8 bits each. Two separate 16-frame counters follow the CRC multiframe and the signaling multiframe. An upstream framer supplies single-cycle strobes that realign these counters.

Static configuration inputs choose what the output marks:
- a one-bit pulse at the start of every frame, of every CRC multiframe, or of every signaling multiframe;
- a level that rises at a signaling multiframe and falls after a CRC multiframe;
- a window that covers timeslot 0 and timeslot 16.

An alternate bit keeps only every second event of each kind. A polarity bit inverts the output.

Top module: `e1_fp_gen`

## Requirements
- R1: While `rst` is high, all counters and state return to bit 0 of frame 0 of both multiframes. On the edge after each reset cycle, `fp_out` equals `inv`, which is the inactive level.
- R2: `inv`=0 makes the output active high. `inv`=1 makes the output active low. The output is registered with one cycle of latency, so the output in a given cycle reflects the bit position of the previous cycle.
- R3: With `ts_win`=1, the output is active for bit positions 0..7 and 128..135 of every frame and inactive for all other positions. This setting overrides `sel` and `alt`.
- R4: With `sel`=00 and `alt`=0, the output is active for exactly one cycle, following bit position 0 of every frame. In every pulse mode (`sel`≠11), no position other than bit 0 produces an active output.
- R5: With `sel`=00 and `alt`=1, only every second frame start is marked. The first frame start after a reset or a configuration change is marked.
- R6: With `sel`=01, a pulse follows bit 0 of frame 0 of the CRC multiframe counter. When `crc_mf_en`=1, `crc_mf_sync` sets that counter so the next frame is frame 0. When `crc_mf_en`=0, the counter runs freely modulo 16, which gives a period of 16 frames.
- R7: With `sel`=10, the behaviour is the same as R6 but uses the signaling multiframe counter, `sig_mf_sync` and `sig_mf_en`.
- R8: With `sel`=01 or 10 and `alt`=1, only every second multiframe start is marked, which gives a 32-frame period when free running.
- R9: With `sel`=11, the output becomes active starting with bit 0 of a marked signaling multiframe start. It stays active through bit 0 of the next marked CRC multiframe start and then becomes inactive. If both starts fall on the same bit, the result is a one-bit pulse. With `alt`=1, every second start of each kind is used.
- R10: `frame_sync` makes the next bit position 0 and counts as the end of a frame for both multiframe counters. A multiframe strobe is ignored while its enable is 0.
- R11: Any change of {`ts_win`,`alt`,`sel`} resets the every-second phases and the level state. As a result, the next event is always marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_sync | input | 1 | Frame alignment strobe; next bit is position 0 |
| crc_mf_sync | input | 1 | CRC multiframe alignment strobe; next frame is frame 0 |
| sig_mf_sync | input | 1 | Signaling multiframe alignment strobe; next frame is frame 0 |
| crc_mf_en | input | 1 | CRC multiframing enabled |
| sig_mf_en | input | 1 | Signaling multiframing enabled |
| sel | input | 2 | Mode: 00 frame, 01 CRC MF, 10 signaling MF, 11 level |
| alt | input | 1 | Mark only every second event |
| inv | input | 1 | Output polarity, 1 = active low |
| ts_win | input | 1 | Timeslot 0/16 window mode |
| fp_out | output | 1 | Framing indication |

## Verification
Several events can fall on the same cycle:
- A configuration change can land on the same cycle as a frame start. It must then both restart the every-second phase and mark that start.
- In level mode, a signaling multiframe start can coincide with a CRC multiframe start.
- A strobe can coincide with the natural wrap of the bit counter.

The bench provokes these cases in two ways. Directed sequences flip `sel` immediately before bit 0. Other sequences issue both multiframe strobes together with `frame_sync`. Seeded random traffic adds strobes and configuration changes at arbitrary positions. A bench reference model predicts each cycle's output, and every cycle is compared against it.

// File: rtl/e1_fp_gen.sv
`timescale 1ns/1ps
module e1_fp_gen #(
  parameter int TS_BITS = 8,
  parameter int TS_NUM  = 32,
  parameter int MF_LEN  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_sync,
  input  logic       crc_mf_sync,
  input  logic       sig_mf_sync,
  input  logic       crc_mf_en,
  input  logic       sig_mf_en,
  input  logic [1:0] sel,
  input  logic       alt,
  input  logic       inv,
  input  logic       ts_win,
  output logic       fp_out
);
  localparam int FRAME_BITS = TS_BITS * TS_NUM;
  localparam int BW         = $clog2(FRAME_BITS);
  localparam int MW         = $clog2(MF_LEN);
  localparam int HALF       = FRAME_BITS / 2;

  logic [BW-1:0] bit_cnt;
  logic [MW-1:0] crc_fr, sig_fr;
  logic [2:0]    ph;
  logic          lvl, fp_q, active;
  logic [3:0]    cfg_q;

  wire [3:0] cfg      = {ts_win, alt, sel};
  wire       cfg_chg  = cfg != cfg_q;
  wire       frm_end  = frame_sync || (bit_cnt == BW'(FRAME_BITS - 1));
  wire       at_start = bit_cnt == '0;
  wire [2:0] ev       = {at_start && sig_fr == '0, at_start && crc_fr == '0, at_start};
  wire [2:0] ph_eff   = cfg_chg ? 3'b000 : ph;
  wire [2:0] fire     = ev & ~(ph_eff & {3{alt}});
  wire       lvl_eff  = cfg_chg ? 1'b0 : lvl;
  wire       in_win   = (bit_cnt < BW'(TS_BITS)) ||
                        (bit_cnt >= BW'(HALF) && bit_cnt < BW'(HALF + TS_BITS));

  always_comb begin
    if (ts_win) active = in_win;
    else begin
      case (sel)
        2'b00:   active = fire[0];
        2'b01:   active = fire[1];
        2'b10:   active = fire[2];
        default: active = fire[2] | lvl_eff;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      crc_fr  <= '0;
      sig_fr  <= '0;
      ph      <= '0;
      lvl     <= 1'b0;
      fp_q    <= inv;
      cfg_q   <= cfg;
    end else begin
      bit_cnt <= frm_end ? '0 : bit_cnt + 1'b1;
      if (crc_mf_en && crc_mf_sync) crc_fr <= '0;
      else if (frm_end) crc_fr <= (crc_fr == MW'(MF_LEN - 1)) ? '0 : crc_fr + 1'b1;
      if (sig_mf_en && sig_mf_sync) sig_fr <= '0;
      else if (frm_end) sig_fr <= (sig_fr == MW'(MF_LEN - 1)) ? '0 : sig_fr + 1'b1;
      ph      <= ph_eff ^ ev;
      lvl     <= fire[1] ? 1'b0 : (fire[2] ? 1'b1 : lvl_eff);
      fp_q    <= active ^ inv;
      cfg_q   <= cfg;
    end
  end

  assign fp_out = fp_q;

  p_rst_idle_r1: assert property (@(posedge clk) rst |=> fp_out == $past(inv));

  p_ts_window_r3: assert property (@(posedge clk) disable iff (rst)
    (ts_win && bit_cnt == BW'(TS_BITS / 2)) |=> fp_out != $past(inv));

  p_first_bit_only_r4: assert property (@(posedge clk) disable iff (rst)
    (!ts_win && sel != 2'b11 && bit_cnt != '0) |=> fp_out == $past(inv));

  p_frame_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (!ts_win && sel == 2'b00 && !alt && bit_cnt == '0) |=> fp_out != $past(inv));
endmodule

// File: tb/test_e1_fp_gen.sv
`timescale 1ns/1ps
module test_e1_fp_gen;
  logic clk = 1'b0, rst = 1'b1;
  logic frame_sync = 0, crc_mf_sync = 0, sig_mf_sync = 0, crc_mf_en = 1, sig_mf_en = 1;
  logic [1:0] sel = 2'b00;
  logic alt = 0, inv = 0, ts_win = 0;
  wire  fp_out;

  int n_run = 0, n_fail = 0;
  string tg = "R1";
  int mb = 0, mc = 0, ms = 0, p0 = 0, p1 = 0, p2 = 0, ml = 0, mq = 0, mcfg = 0;
  bit done = 0;

  always #2 clk = ~clk;

  e1_fp_gen i_e1_fp_gen (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .crc_mf_sync(crc_mf_sync),
    .sig_mf_sync(sig_mf_sync), .crc_mf_en(crc_mf_en), .sig_mf_en(sig_mf_en),
    .sel(sel), .alt(alt), .inv(inv), .ts_win(ts_win), .fp_out(fp_out));

  function automatic int cfg_word();
    return {28'd0, ts_win, alt, sel};
  endfunction

  function automatic bit in_window(int b);
    return (b < 8) || (b >= 128 && b < 136);
  endfunction

  function automatic string mode_tag();
    if (ts_win) return "R3";
    if (inv) return "R2";
    case (sel)
      2'b00: return alt ? "R5" : "R4";
      2'b01: return alt ? "R8" : "R6";
      2'b10: return alt ? "R8" : "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic predict();
    int e0, e1, e2, f0, f1, f2, act, lv, wrap;
    if (rst) begin
      mb = 0; mc = 0; ms = 0; p0 = 0; p1 = 0; p2 = 0; ml = 0; mq = inv; mcfg = cfg_word();
      return;
    end
    if (cfg_word() != mcfg) begin p0 = 0; p1 = 0; p2 = 0; ml = 0; end
    e0 = (mb == 0);
    e1 = e0 && mc == 0;
    e2 = e0 && ms == 0;
    f0 = e0 && !(alt && p0);
    f1 = e1 && !(alt && p1);
    f2 = e2 && !(alt && p2);
    lv = ml;
    if (ts_win) act = in_window(mb);
    else case (sel)
      2'b00: act = f0;
      2'b01: act = f1;
      2'b10: act = f2;
      default: act = f2 || lv;
    endcase
    p0 ^= e0; p1 ^= e1; p2 ^= e2;
    ml = f1 ? 0 : (f2 ? 1 : lv);
    mq = act ^ inv;
    wrap = frame_sync || mb == 255;
    if (crc_mf_en && crc_mf_sync) mc = 0; else if (wrap) mc = (mc + 1) % 16;
    if (sig_mf_en && sig_mf_sync) ms = 0; else if (wrap) ms = (ms + 1) % 16;
    mb = wrap ? 0 : mb + 1;
    mcfg = cfg_word();
  endtask

  task automatic tick();
    predict();
    @(negedge clk);
    n_run++;
    if (fp_out !== mq[0]) begin
      n_fail++;
      $display("FAIL %s: fp_out=%0b expected %0b at %0t", tg, fp_out, mq[0], $time);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic strobe_at_wrap(bit c, bit s);
    while (mb != 255) tick();
    frame_sync = 1; crc_mf_sync = c; sig_mf_sync = s;
    tick();
    frame_sync = 0; crc_mf_sync = 0; sig_mf_sync = 0;
  endtask

  task automatic do_reset(bit pol);
    inv = pol; rst = 1; tg = "R1";
    run(3);
    rst = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset(0);
    tg = "R4"; run(600);
    do_reset(1);
    tg = "R2"; run(600);
    do_reset(0);
    alt = 1; tg = "R5"; run(1100);
    alt = 0; ts_win = 1; tg = "R3"; run(600);
    ts_win = 0; sel = 2'b01; tg = "R6"; crc_mf_en = 1;
    strobe_at_wrap(1, 0); run(4200);
    strobe_at_wrap(1, 1); run(4200);
    crc_mf_en = 0; tg = "R10";
    for (int k = 0; k < 9000; k++) begin
      crc_mf_sync = ($urandom % 700 == 0);
      tick();
    end
    crc_mf_sync = 0; crc_mf_en = 1;
    sel = 2'b10; tg = "R7"; strobe_at_wrap(0, 1); run(9000);
    sel = 2'b01; alt = 1; tg = "R8"; sig_mf_en = 0; run(17000); sig_mf_en = 1;
    sel = 2'b11; alt = 0; tg = "R9";
    strobe_at_wrap(1, 1); run(5000);
    for (int k = 0; k < 5; k++) strobe_at_wrap(0, 1);
    run(9000);
    alt = 1; strobe_at_wrap(1, 0); run(17000);
    sel = 2'b00; alt = 0; tg = "R10";
    for (int k = 0; k < 8; k++) begin
      run(30 + $urandom % 200);
      frame_sync = 1; tick(); frame_sync = 0;
    end
    run(300);
    alt = 1; tg = "R11";
    for (int k = 0; k < 10; k++) begin
      while (mb != 255) tick();
      sel = (k % 2) ? 2'b00 : 2'b01;
      tick(); run(3);
      sel = 2'b00;
    end
    run(600);
    for (int k = 0; k < 40000; k++) begin
      if ($urandom % 2000 == 0) begin
        sel = 2'($urandom); alt = 1'($urandom); inv = 1'($urandom);
        ts_win = ($urandom % 5 == 0); crc_mf_en = 1'($urandom); sig_mf_en = 1'($urandom);
      end
      frame_sync  = ($urandom % 3000 == 0);
      crc_mf_sync = ($urandom % 1500 == 0);
      sig_mf_sync = ($urandom % 1500 == 0);
      tg = mode_tag();
      tick();
    end
    frame_sync = 0; crc_mf_sync = 0; sig_mf_sync = 0;
    do_reset(1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule